// File: doc/BRIEF.md
# Bank Sparse Hit String Encoder

This block compresses one row of a 64-column bank of binary pixel hits into a short list of run descriptors. After a row strobe it walks the row from the lowest column upward and finds one run of adjacent hit pixels per clock cycle. Each run becomes an 8-bit state word that holds the run's starting column and its length. Runs longer than four pixels are cut into pieces of at most four.

Three extra input bits carry the first columns of the neighbouring bank. A run that starts inside this bank can therefore extend across the boundary and still be measured correctly. A run that starts in those borrowed columns is left to the neighbour. At most six states are kept per row. When more runs exist, an overflow flag is set and the extra runs are dropped. A status count, a latched bank address and a done flag complete the output set for the downstream multiplexer.

Top module: `hitStringEncoder`

## Requirements
- R1: After reset, done, overflow, stateCount, bankAddr and every bit of stateWords are 0.
- R2: A rowStrobe cycle captures rowBits, lookAhead and bankSel. On the next cycle done, overflow and stateCount are 0, and bankAddr equals the captured bankSel. A strobe that arrives during a scan abandons that scan and starts over on the new row.
- R3: State slot i occupies stateWords[8i+7:8i]. Bits [7:2] hold the start column and bits [1:0] hold the run length minus one. Slots fill in increasing column order, starting at slot 0.
- R4: A run of more than 4 adjacent hits is split. Its first 4 pixels form one state, and coding resumes at the fifth pixel as a new state.
- R5: lookAhead[j] stands for column 64+j. A run that starts at column 63 or below counts lookAhead pixels toward its length, up to 4 pixels in total. A run that starts inside lookAhead is not coded.
- R6: When a row holds more than 6 runs (after splitting), overflow is 1, stateCount is 6, and the slots hold the first six runs. With 6 runs or fewer, overflow is 0.
- R7: For a row with N runs, done rises max(1, min(N,6)) cycles after the strobe edge. done then stays high, with outputs stable, until the next strobe.
- R8: Slots at index stateCount and above read as zero once done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rowStrobe | input | 1 | Start encoding the presented row |
| rowBits | input | 64 | Hit bits of this bank, bit c = column c |
| lookAhead | input | 3 | First three columns of the next bank (zero for the last bank) |
| bankSel | input | 5 | Bank address captured at the strobe |
| stateWords | output | 48 | Six 8-bit state slots |
| stateCount | output | 3 | Number of states found (0 to 6) |
| overflow | output | 1 | More runs existed than slots |
| done | output | 1 | Scan of the current row finished |
| bankAddr | output | 5 | Latched bank address |

## Verification
The hardest case to reach is a run that straddles the bank edge while a split or the overflow limit is also in play. The length must then come from both rowBits and lookAhead, and nothing may leak into a slot from a run that starts in lookAhead. The stimulus table places runs at columns 62 to 65 and rows made only of lookAhead hits. It also includes seven isolated runs to force overflow and a nine-pixel run that splits twice. Another directed test strobes a new row in the middle of an overflow scan to check that the restart is clean.

// File: rtl/hitStringPkg.sv
package hitStringPkg;
  parameter int NUM_SLOTS = 6;
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);

  typedef struct packed {
    logic load;
    logic step;
    logic [SLOT_W-1:0] slot;
  } scanCtl_t;
endpackage

// File: rtl/hitStringPath.sv
module hitStringPath
  import hitStringPkg::*;
#(
  parameter int COLS = 64,
  parameter int OVERLAP = 3,
  parameter int MAX_RUN = 4,
  parameter int BANK_W = 5,
  localparam int COL_W = $clog2(COLS),
  localparam int LEN_W = $clog2(MAX_RUN),
  localparam int ST_W = COL_W + LEN_W,
  localparam int WIN = COLS + OVERLAP
) (
  input  logic clk,
  input  logic rst,
  input  scanCtl_t ctl,
  input  logic [COLS-1:0] rowBits,
  input  logic [OVERLAP-1:0] lookAhead,
  input  logic [BANK_W-1:0] bankSel,
  output logic found,
  output logic restAny,
  output logic [NUM_SLOTS*ST_W-1:0] stateWords,
  output logic [BANK_W-1:0] bankAddr
);
  logic [WIN-1:0] work;
  logic [ST_W-1:0] slotReg [NUM_SLOTS];
  logic [COL_W-1:0] firstCol;
  logic [WIN-1:0] shifted;
  logic [LEN_W:0] runLen;
  logic [WIN-1:0] lenMask;
  logic stopRun;

  // lowest set column inside the bank; lookAhead columns never start a run
  always_comb begin
    found = 1'b0;
    firstCol = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (work[i]) begin
        found = 1'b1;
        firstCol = COL_W'(i);
      end
    end
  end

  // run length from the start column, capped, may extend into lookAhead
  always_comb begin
    shifted = work >> firstCol;
    runLen = '0;
    stopRun = 1'b0;
    for (int k = 0; k < MAX_RUN; k++) begin
      if (!stopRun && shifted[k]) runLen = runLen + 1'b1;
      else stopRun = 1'b1;
    end
    lenMask = ((WIN'(1) << runLen) - WIN'(1)) << firstCol;
    restAny = |(work[COLS-1:0] & ~lenMask[COLS-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work <= '0;
      bankAddr <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) slotReg[s] <= '0;
    end else if (ctl.load) begin
      work <= {lookAhead, rowBits};
      bankAddr <= bankSel;
      for (int s = 0; s < NUM_SLOTS; s++) slotReg[s] <= '0;
    end else if (ctl.step && found) begin
      work <= work & ~lenMask;
      slotReg[ctl.slot] <= {firstCol, LEN_W'(runLen - 1'b1)};
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gPack
    assign stateWords[g*ST_W +: ST_W] = slotReg[g];
  end

  // R8
  slots_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (stateWords == '0));
endmodule

// File: rtl/hitStringCtrl.sv
module hitStringCtrl
  import hitStringPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rowStrobe,
  input  logic found,
  input  logic restAny,
  output scanCtl_t ctl,
  output logic [CNT_W-1:0] stateCount,
  output logic overflow,
  output logic done
);
  logic busy;
  logic [CNT_W-1:0] nextCnt;
  logic lastSlot;

  assign nextCnt = stateCount + 1'b1;
  assign lastSlot = (nextCnt == CNT_W'(NUM_SLOTS));
  assign ctl.load = rowStrobe;
  assign ctl.step = busy && !rowStrobe;
  assign ctl.slot = SLOT_W'(stateCount);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      stateCount <= '0;
      overflow <= 1'b0;
      done <= 1'b0;
    end else if (rowStrobe) begin
      busy <= 1'b1;
      stateCount <= '0;
      overflow <= 1'b0;
      done <= 1'b0;
    end else if (busy) begin
      if (!found) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        stateCount <= nextCnt;
        if (!restAny || lastSlot) begin
          busy <= 1'b0;
          done <= 1'b1;
          overflow <= restAny && lastSlot;
        end
      end
    end
  end

  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    stateCount <= CNT_W'(NUM_SLOTS));
  // R6
  ovf_full_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (stateCount == CNT_W'(NUM_SLOTS)));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !rowStrobe) |=> (done && $stable(stateCount) && $stable(overflow)));
  // R2
  strobe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rowStrobe |=> (!done && !overflow && stateCount == '0));
endmodule

// File: rtl/hitStringEncoder.sv
module hitStringEncoder
  import hitStringPkg::*;
#(
  parameter int COLS = 64,
  parameter int OVERLAP = 3,
  parameter int MAX_RUN = 4,
  parameter int BANK_W = 5,
  localparam int ST_W = $clog2(COLS) + $clog2(MAX_RUN)
) (
  input  logic clk,
  input  logic rst,
  input  logic rowStrobe,
  input  logic [COLS-1:0] rowBits,
  input  logic [OVERLAP-1:0] lookAhead,
  input  logic [BANK_W-1:0] bankSel,
  output logic [NUM_SLOTS*ST_W-1:0] stateWords,
  output logic [CNT_W-1:0] stateCount,
  output logic overflow,
  output logic done,
  output logic [BANK_W-1:0] bankAddr
);
  scanCtl_t ctl;
  logic found;
  logic restAny;

  hitStringCtrl uCtrl (
    .clk(clk), .rst(rst), .rowStrobe(rowStrobe), .found(found),
    .restAny(restAny), .ctl(ctl), .stateCount(stateCount),
    .overflow(overflow), .done(done)
  );

  hitStringPath #(
    .COLS(COLS), .OVERLAP(OVERLAP), .MAX_RUN(MAX_RUN), .BANK_W(BANK_W)
  ) uPath (
    .clk(clk), .rst(rst), .ctl(ctl), .rowBits(rowBits),
    .lookAhead(lookAhead), .bankSel(bankSel), .found(found),
    .restAny(restAny), .stateWords(stateWords), .bankAddr(bankAddr)
  );
endmodule

// File: tb/sim_hitStringEncoder.sv
module sim_hitStringEncoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rowStrobe = 1'b0;
  logic [63:0] rowBits = '0;
  logic [2:0] lookAhead = '0;
  logic [4:0] bankSel = '0;
  logic [47:0] stateWords;
  logic [2:0] stateCount;
  logic overflow;
  logic done;
  logic [4:0] bankAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hitStringEncoder u0 (
    .clk(clk), .rst(rst), .rowStrobe(rowStrobe), .rowBits(rowBits),
    .lookAhead(lookAhead), .bankSel(bankSel), .stateWords(stateWords),
    .stateCount(stateCount), .overflow(overflow), .done(done),
    .bankAddr(bankAddr)
  );

  typedef struct packed {
    logic [63:0] row;
    logic [2:0] look;
    logic [2:0] cnt;
    logic ovf;
    logic [47:0] st;
    logic [3:0] lat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    // R7 empty row
    '{64'h0, 3'b000, 3'd0, 1'b0, 48'h0, 4'd1},
    // R3 two runs: col0 len1, col10 len3
    '{64'h0000_0000_0000_1C01, 3'b000, 3'd2, 1'b0, 48'h0000_0000_2A00, 4'd2},
    // R4 five-pixel run at 20 splits
    '{64'h0000_0000_01F0_0000, 3'b000, 3'd2, 1'b0, 48'h0000_0000_6053, 4'd2},
    // R5 run 62..65 crosses into lookAhead
    '{64'hC000_0000_0000_0000, 3'b011, 3'd1, 1'b0, 48'h0000_0000_00FB, 4'd1},
    // R5 run only in lookAhead is not coded
    '{64'h0, 3'b111, 3'd0, 1'b0, 48'h0, 4'd1},
    // R6 seven isolated runs overflow
    '{64'h0000_0000_0000_1555, 3'b000, 3'd6, 1'b1, 48'h2820_1810_0800, 4'd6},
    // R6 exactly six runs, no overflow
    '{64'h0000_0000_0000_0555, 3'b000, 3'd6, 1'b0, 48'h2820_1810_0800, 4'd6},
    // R4 nine-pixel run at 40 splits twice
    '{64'h0001_FF00_0000_0000, 3'b000, 3'd3, 1'b0, 48'h0000_00C0_B3A3, 4'd3}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic strobeRow(input logic [63:0] r, input logic [2:0] l,
                           input logic [4:0] b);
    @(negedge clk);
    rowBits = r;
    lookAhead = l;
    bankSel = b;
    rowStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rowStrobe = 1'b0;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "overflow", 64'(overflow), 64'd0);
    check("R1", "count", 64'(stateCount), 64'd0);
    check("R1", "states", 64'(stateWords), 64'd0);
    check("R1", "bankAddr", 64'(bankAddr), 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      strobeRow(VEC[v].row, VEC[v].look, 5'(v));
      // R2 cleared right after the strobe edge
      check("R2", "done after strobe", 64'(done), 64'd0);
      waitDone(lat);
      check("R7", "latency", 64'(lat), 64'(VEC[v].lat));
      check("R3", "count", 64'(stateCount), 64'(VEC[v].cnt));
      check("R6", "overflow", 64'(overflow), 64'(VEC[v].ovf));
      check("R8", "state words", 64'(stateWords), 64'(VEC[v].st));
    end

    // R2 bank address captured at strobe and held
    strobeRow(64'h0000_0000_0000_8000, 3'b000, 5'd17);
    bankSel = 5'd3;
    waitDone(lat);
    check("R2", "bankAddr", 64'(bankAddr), 64'd17);
    check("R3", "single col15", 64'(stateWords), 64'h3C);

    // R7 done held with stable outputs while inputs change
    rowBits = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R7", "done hold", 64'(done), 64'd1);
    check("R7", "states hold", 64'(stateWords), 64'h3C);
    check("R7", "count hold", 64'(stateCount), 64'd1);

    // R2 restart in mid scan of an overflowing row
    strobeRow(64'h0000_0000_0000_1555, 3'b000, 5'd1);
    @(posedge clk);
    @(negedge clk);
    strobeRow(VEC[1].row, 3'b000, 5'd2);
    waitDone(lat);
    check("R2", "restart count", 64'(stateCount), 64'd2);
    check("R2", "restart states", 64'(stateWords), 64'h2A00);
    check("R2", "restart ovf", 64'(overflow), 64'd0);
    check("R7", "restart latency", 64'(lat), 64'd2);

    // R5 run at 63 with lookAhead gap: col63 len1, lookAhead run ignored
    strobeRow(64'h8000_0000_0000_0000, 3'b110, 5'd0);
    waitDone(lat);
    check("R5", "edge run", 64'(stateWords), 64'hFC);
    check("R5", "edge count", 64'(stateCount), 64'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule